// File: doc/BRIEF.md
# Addend-Trimmed Nanosecond Time Counter

This block keeps a 64-bit nanosecond time of day that runs from a reference clock. A 32-bit phase accumulator adds a programmable addend on every enabled reference cycle. Each carry out of the accumulator is one nominal tick, and the time counter then advances by a programmable whole number of nanoseconds. The nominal tick rate is therefore the reference rate scaled by addend / 2^32. Software can trim that rate in steps far below one part per billion, instead of being tied to an integer divider. The reference rate must stay above the nominal tick rate, so the addend is always below 2^32.

A prescaler counts nominal ticks and emits a one-cycle output pulse once per programmed number of ticks. One output period is the prescale times the nominal period. For example, a 10 ns period and a prescale of 100 give one pulse per microsecond. A time-load write replaces the counter and restarts the prescaler, so pulses stay aligned to the loaded time. A 2-bit reference-select code is held for an external clock mux and resets to 1, which selects the system clock.

Configuration uses a synchronous write port on the reference clock. The register selects are: 0 control (bit 0 enable, bits 2:1 reference select), 1 addend, 2 period in ns (low 8 bits), 3 prescale (low 16 bits), 4 staged low time word, 5 high time word. A write to select 5 loads the time counter with the written high word and the staged low word.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, time_ns is 0, tick_out is 0, ref_sel is 2'b01 and the timer is disabled.
- R2: While enabled, one nominal tick occurs in each reference cycle in which accumulator + addend carries out of bit 31. With addend 0x8000_0000, exactly one tick occurs in every two cycles.
- R3: On each nominal tick, time_ns increases by the programmed period, visible after that clock edge.
- R4: tick_out pulses high for one cycle after every prescale-th nominal tick. A prescale of 0 or 1 pulses on every tick. With a 10 ns period and a prescale of 100, pulses fall on time_ns values that are multiples of 1000 and are 100 ticks apart.
- R5: An addend write takes effect from the next reference cycle and clears neither the accumulator nor the time counter.
- R6: A write to select 5 loads time_ns with {written word, staged low word} after that edge. It takes priority over a tick in the same cycle and clears the prescaler count, so the next pulse comes after a full prescale of ticks.
- R7: While enable is 0, the accumulator, the time counter and the prescaler count hold their values, and tick_out stays 0.
- R8: A control write sets ref_sel from data bits 2:1, visible after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| time_ns | output | 64 | Nanosecond time of day |
| tick_out | output | 1 | Prescaled output pulse, one cycle wide |
| ref_sel | output | 2 | Reference clock select code for an external mux |

## Verification
Every cycle, the assertions check four behaviours: a load reproduces the loaded word, each tick adds exactly one period, disabled or tickless cycles leave time and the accumulator unchanged, and every output pulse traces back to a counted tick. Some properties cannot be seen from one cycle. These are the long-run tick rate set by the addend, the one-cycle deferral of an addend change, the microsecond alignment of pulses after a load, and the prescale 0 and 1 corner cases. Only the bench scenarios show these, with a cycle-by-cycle scoreboard against a model built from the requirements.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int ACC_W  = 32;
  localparam int TIME_W = 64;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] SEL_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_ADDEND = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_PERIOD = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_PRESC  = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_TLO    = 3'd4;
  localparam logic [ADDR_W-1:0] SEL_THI    = 3'd5;

  localparam logic [1:0] REF_SEL_RST = 2'b01;
endpackage

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] addend,
  output logic         tick
);
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;
  logic         carry;

  always_comb begin
    {carry, acc_d} = {1'b0, acc_q} + {1'b0, addend};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign tick = en & carry;

  // R7: a disabled cycle leaves the phase untouched
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/ptp_tod_count.sv
module ptp_tod_count #(
  parameter int TIME_W   = 64,
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic [PERIOD_W-1:0] period,
  input  logic                load,
  input  logic [TIME_W-1:0]   load_val,
  output logic [TIME_W-1:0]   time_q
);
  logic [TIME_W-1:0] time_d;

  always_comb begin
    time_d = time_q;
    if (load)     time_d = load_val;
    else if (adv) time_d = time_q + TIME_W'(period);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  p_load_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> time_q == $past(load_val));
  p_step_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> time_q == $past(time_q) + TIME_W'($past(period)));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(time_q));
endmodule

// File: rtl/ptp_tick_div.sv
module ptp_tick_div #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               clr,
  input  logic [PRESC_W-1:0] presc,
  output logic               pulse_q
);
  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] cnt_d;
  logic               pulse_d;
  logic               wrap;

  always_comb begin
    wrap    = (presc <= PRESC_W'(1)) || (cnt_q >= presc - PRESC_W'(1));
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (wrap) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + PRESC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  // R4: every pulse follows a counted tick
  p_pulse_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(tick && !clr));
  // R7: no tick, no load, count holds
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int          PERIOD_W   = 8,
  parameter int          PRESC_W    = 16,
  parameter logic [31:0] ADDEND_RST = 32'hCCCC_CCCD,
  parameter int          PERIOD_RST = 10,
  parameter int          PRESC_RST  = 100
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [TIME_W-1:0] time_ns,
  output logic              tick_out,
  output logic [1:0]        ref_sel
);
  localparam int HALF_W = TIME_W / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // configuration registers
  logic                enable_q, enable_d;
  logic [1:0]          sel_q, sel_d;
  logic [ACC_W-1:0]    addend_q, addend_d;
  logic [PERIOD_W-1:0] period_q, period_d;
  logic [PRESC_W-1:0]  presc_q, presc_d;
  logic [HALF_W-1:0]   tlo_q, tlo_d;
  logic                load;
  logic [TIME_W-1:0]   load_val;

  always_comb begin
    enable_d = enable_q;
    sel_d    = sel_q;
    addend_d = addend_q;
    period_d = period_q;
    presc_d  = presc_q;
    tlo_d    = tlo_q;
    if (wr_en) begin
      case (wr_addr)
        SEL_CTRL: begin
          enable_d = wr_data[0];
          sel_d    = wr_data[2:1];
        end
        SEL_ADDEND: addend_d = wr_data[ACC_W-1:0];
        SEL_PERIOD: period_d = wr_data[PERIOD_W-1:0];
        SEL_PRESC:  presc_d  = wr_data[PRESC_W-1:0];
        SEL_TLO:    tlo_d    = wr_data[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_ref or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      enable_q <= 1'b0;
      sel_q    <= REF_SEL_RST;
      addend_q <= ADDEND_RST;
      period_q <= PERIOD_W'(PERIOD_RST);
      presc_q  <= PRESC_W'(PRESC_RST);
      tlo_q    <= '0;
    end else begin
      enable_q <= enable_d;
      sel_q    <= sel_d;
      addend_q <= addend_d;
      period_q <= period_d;
      presc_q  <= presc_d;
      tlo_q    <= tlo_d;
    end
  end

  assign load     = wr_en && (wr_addr == SEL_THI);
  assign load_val = {wr_data[HALF_W-1:0], tlo_q};
  assign ref_sel  = sel_q;

  logic nom_tick;

  ptp_phase_acc #(.W(ACC_W)) u_acc (
    .clk    (clk_ref),
    .rst_n  (rst_sync_n),
    .en     (enable_q),
    .addend (addend_q),
    .tick   (nom_tick)
  );

  ptp_tod_count #(.TIME_W(TIME_W), .PERIOD_W(PERIOD_W)) u_tod (
    .clk      (clk_ref),
    .rst_n    (rst_sync_n),
    .adv      (nom_tick),
    .period   (period_q),
    .load     (load),
    .load_val (load_val),
    .time_q   (time_ns)
  );

  ptp_tick_div #(.PRESC_W(PRESC_W)) u_div (
    .clk     (clk_ref),
    .rst_n   (rst_sync_n),
    .tick    (nom_tick),
    .clr     (load),
    .presc   (presc_q),
    .pulse_q (tick_out)
  );

  p_addend_write_r5: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (wr_en && wr_addr == SEL_ADDEND) |=> addend_q == $past(wr_data));
  p_off_hold_r7: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (!enable_q && !load) |=> ($stable(time_ns) && !tick_out));
  p_sel_write_r8: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (wr_en && wr_addr == SEL_CTRL) |=> ref_sel == $past(wr_data[2:1]));
endmodule

// File: tb/sim_ptp_time_counter.sv
module sim_ptp_time_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [63:0] time_ns;
  logic        tick_out;
  logic [1:0]  ref_sel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ptp_time_counter u0 (
    .clk_ref (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .time_ns (time_ns), .tick_out (tick_out), .ref_sel (ref_sel)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model + scoreboard ----------------
  typedef struct { logic [63:0] t; logic k; } exp_t;
  exp_t sbq[$];

  logic        m_en;
  logic [31:0] m_add, m_lo, m_acc;
  logic [7:0]  m_per;
  logic [15:0] m_pre, m_cnt;
  logic [63:0] m_time;
  logic        m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_add = 32'hCCCC_CCCD; m_per = 8'd10; m_pre = 16'd100;
      m_lo = 0; m_acc = 0; m_time = 0; m_cnt = 0; m_out = 0;
      sbq.delete();
    end else begin
      logic [32:0] s;
      logic        tk, ld;
      s  = {1'b0, m_acc} + {1'b0, m_add};
      tk = m_en && s[32];
      ld = wr_en && wr_addr == 3'd5;
      if (m_en) m_acc = s[31:0];
      if (ld) m_time = {wr_data, m_lo};
      else if (tk) m_time = m_time + 64'(m_per);
      m_out = 0;
      if (ld) m_cnt = 0;
      else if (tk) begin
        if (m_pre <= 1 || m_cnt + 16'd1 >= m_pre) begin m_cnt = 0; m_out = 1; end
        else m_cnt = m_cnt + 16'd1;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_en  = wr_data[0];
          3'd1: m_add = wr_data;
          3'd2: m_per = wr_data[7:0];
          3'd3: m_pre = wr_data[15:0];
          3'd4: m_lo  = wr_data;
          default: ;
        endcase
      end
      sbq.push_back('{t: m_time, k: m_out});
    end
  end

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk("R3 scoreboard time", time_ns, e.t);
      chk("R4 scoreboard tick_out", 64'(tick_out), 64'(e.k));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] t0;
    int last, pulses, gap_bad;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    chk("R1 time after reset", time_ns, 64'd0);
    chk("R1 tick_out after reset", 64'(tick_out), 64'd0);
    chk("R1 ref_sel after reset", 64'(ref_sel), 64'd1);
    idle(10);
    chk("R1 disabled after reset", time_ns, 64'd0);

    // R4: 10 ns period, prescale 100 -> 1 us pulses
    wr(3'd2, 32'd10); wr(3'd3, 32'd100); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'd0); wr(3'd5, 32'd0);
    wr(3'd0, 32'd3);
    last = -1; pulses = 0; gap_bad = 0;
    for (int c = 0; c < 450; c++) begin
      @(negedge clk);
      if (tick_out) begin
        chk("R4 pulse on microsecond", time_ns % 1000, 64'd0);
        if (last >= 0 && c - last != 100) gap_bad++;
        last = c; pulses++;
      end
    end
    chk("R4 pulse count", 64'(pulses >= 4), 64'd1);
    chk("R4 pulse spacing", 64'(gap_bad), 64'd0);

    // R2/R5: half-rate addend
    wr(3'd1, 32'h8000_0000);
    idle(1);
    t0 = time_ns;
    idle(200);
    chk("R2 half-rate ticks", time_ns - t0, 64'd1000);

    // R7: disable holds everything
    wr(3'd0, 32'd2);
    idle(1);
    t0 = time_ns; pulses = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (tick_out) pulses++;
    end
    wr(3'd1, 32'hFFFF_FFFF);
    idle(5);
    chk("R7 time held while off", time_ns, t0);
    chk("R7 no pulse while off", 64'(pulses), 64'd0);

    // R6: load while off, then alignment
    wr(3'd4, 32'h10); wr(3'd5, 32'h1);
    chk("R6 loaded value", time_ns, 64'h1_0000_0010);
    wr(3'd0, 32'd3);
    pulses = 0;
    for (int c = 0; c < 130 && pulses == 0; c++) begin
      @(negedge clk);
      if (tick_out) begin
        pulses++;
        chk("R6 first pulse after full prescale", time_ns, 64'h1_0000_0010 + 64'd1000);
      end
    end
    chk("R6 pulse seen", 64'(pulses), 64'd1);

    // R6: load beats tick while running
    wr(3'd4, 32'h0000_0500); wr(3'd5, 32'h2);
    chk("R6 load priority over tick", time_ns, 64'h2_0000_0500);
    idle(3);

    // R8: reference select
    wr(3'd0, 32'd5);
    chk("R8 ref_sel=2", 64'(ref_sel), 64'd2);
    wr(3'd0, 32'd7);
    chk("R8 ref_sel=3", 64'(ref_sel), 64'd3);

    // R4 corner: prescale 1 and 0
    wr(3'd3, 32'd1);
    idle(2);
    pulses = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (tick_out) pulses++; end
    chk("R4 prescale 1 every tick", 64'(pulses >= 19), 64'd1);
    wr(3'd3, 32'd0);
    idle(2);
    pulses = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (tick_out) pulses++; end
    chk("R4 prescale 0 every tick", 64'(pulses >= 19), 64'd1);

    // R5: addend change mid-run, period change
    wr(3'd2, 32'd8);
    wr(3'd1, 32'h4000_0000);
    idle(1);
    t0 = time_ns;
    idle(400);
    chk("R5 quarter-rate ticks", time_ns - t0, 64'd800);

    idle(2);
    finish_run();
  end
endmodule